// File: doc/BRIEF.md
# PLL Fast-Lock Sequencer

This block shortens PLL settling by opening a temporary boost window just after the VCO band search finishes. The window opens only when three conditions hold: the clock-divider mode field selects fast-lock, the user's charge-pump current code is zero, and both the modulus M and the clock divider CDIV are non-zero. While the window is open, the block forces the charge-pump code to its maximum. It also switches part of the loop-filter shunt resistance to ground, which lowers the loop-filter resistance during the boost.

The window lasts exactly M × CDIV phase-detector clock cycles. The block latches that product when the window opens. When the count runs out, the charge-pump code goes back to the user value and the switch returns to high impedance. A new qualifying done pulse during the window starts the count again from zero. A done pulse that does not qualify leaves the window running. The whole block runs on the phase-detector clock and has an active-high synchronous reset.

Top module: `pll_fastlock_seq`

## Requirements
- R1: A fast-lock window opens only if `clkdiv_mode` equals 2'b01 in the cycle the done pulse is sampled. Any other mode value gives no window.
- R2: A fast-lock window opens only if `cp_user` equals 4'b0000 in the cycle the done pulse is sampled. Any other code gives no window.
- R3: With `vas_done` held low, an idle block stays idle indefinitely.
- R4: While the window is open, `cp_eff` equals 4'b1111.
- R5: `sw_gnd` is 1 (drive to ground) exactly while the window is open and 0 (high impedance) at all other times.
- R6: A qualifying pulse sampled at clock edge k makes the window open from edge k to edge k + M×CDIV. Outputs are therefore active for exactly M×CDIV cycles.
- R7: Outside the window, `cp_eff` equals `cp_user` in the same cycle.
- R8: If `mod_m` or `clk_div` is zero when the pulse is sampled, no window opens.
- R9: A qualifying pulse during an open window restarts the count from zero. A non-qualifying pulse during the window has no effect on its length.
- R10: `busy` is high for exactly the cycles of the window.
- R11: A synchronous reset closes any open window by the next edge. It leaves `busy` and `sw_gnd` low and `cp_eff` equal to `cp_user`.
- R12: Changes to `mod_m` or `clk_div` while the window is open do not change its length, because the product is latched when the window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst | input | 1 | Synchronous reset, active high |
| vas_done | input | 1 | One-cycle pulse when VCO auto-selection completes |
| clkdiv_mode | input | 2 | Clock-divider mode; 2'b01 enables fast-lock |
| cp_user | input | 4 | User charge-pump current code |
| mod_m | input | 12 | Modulus M |
| clk_div | input | 12 | Clock divider CDIV |
| cp_eff | output | 4 | Charge-pump code applied to the pump |
| sw_gnd | output | 1 | 1 = loop-filter switch to ground, 0 = high impedance |
| busy | output | 1 | High while the fast-lock window is open |

## Verification
Every output is a direct function of one state register. A pulse driven before edge k therefore shows on `busy`, `sw_gnd` and `cp_eff` right after edge k, and a reset shows right after the edge that samples it. The bench drives inputs on falling edges and samples on the following falling edge. It then counts open cycles until `busy` drops and compares the count with M×CDIV, or with zero when any gate fails. Restart cases count the cycles before and after the second pulse separately and expect their sum.

// File: rtl/pll_fastlock_seq.sv
module pll_fastlock_seq #(
  parameter int MW = 12,
  parameter int CW = 12,
  parameter int CPW = 4,
  parameter logic [1:0] MODE_FL = 2'b01
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vas_done,
  input  logic [1:0]     clkdiv_mode,
  input  logic [CPW-1:0] cp_user,
  input  logic [MW-1:0]  mod_m,
  input  logic [CW-1:0]  clk_div,
  output logic [CPW-1:0] cp_eff,
  output logic           sw_gnd,
  output logic           busy
);
  localparam int PW = MW + CW;

  logic          open_q;
  logic [PW-1:0] cnt_q, lim_q;

  wire [PW-1:0] prod = PW'(mod_m) * PW'(clk_div);
  wire arm  = vas_done && (clkdiv_mode == MODE_FL) && (cp_user == '0) && (prod != '0);
  wire last = (cnt_q == lim_q - PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (arm) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
      lim_q  <= prod;
    end else if (open_q) begin
      if (last) open_q <= 1'b0;
      else      cnt_q  <= cnt_q + PW'(1);
    end
  end

  assign busy   = open_q;
  assign sw_gnd = open_q;
  assign cp_eff = open_q ? '1 : cp_user;

  // R1 R2 R8
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(vas_done) && $past(clkdiv_mode) == MODE_FL &&
                      $past(cp_user) == '0 && $past(mod_m) != '0 && $past(clk_div) != '0);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !open_q && !vas_done |=> !open_q);

  // R6
  early_close_chk: assert property (@(posedge clk) disable iff (rst)
    open_q && !vas_done && !last |=> open_q);

  // R6 R12
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    open_q |-> cnt_q < lim_q);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    open_q && arm |=> open_q && cnt_q == '0);

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !open_q);
endmodule

// File: tb/pll_fastlock_seq_tb.sv
module pll_fastlock_seq_tb_top;
  logic clk = 1'b0, rst = 1'b1, vas_done = 1'b0;
  logic [1:0] clkdiv_mode = 2'b00;
  logic [3:0] cp_user = 4'h0;
  logic [11:0] mod_m = 12'd0, clk_div = 12'd0;
  logic [3:0] cp_eff;
  logic sw_gnd, busy;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  pll_fastlock_seq dut_i (.clk(clk), .rst(rst), .vas_done(vas_done), .clkdiv_mode(clkdiv_mode),
    .cp_user(cp_user), .mod_m(mod_m), .clk_div(clk_div), .cp_eff(cp_eff), .sw_gnd(sw_gnd), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts open cycles from the current sample point; checks R4 R5 R10 each cycle
  task automatic count_open(output int n);
    n = 0;
    while (busy && n < 5000) begin
      if (cp_eff != 4'hF || !sw_gnd) begin
        chk(0, "R4/R5 during window", {cp_eff, sw_gnd}, 31);
      end
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse();
    vas_done = 1'b1;
    @(negedge clk);
    vas_done = 1'b0;
  endtask

  initial begin
    int n, n2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && sw_gnd == 0 && cp_eff == cp_user, "R11 reset state", busy, 0);

    // R3: no pulse, stays idle
    clkdiv_mode = 2'b01; cp_user = 0; mod_m = 3; clk_div = 3;
    begin
      bit idle_ok = 1;
      for (int i = 0; i < 20; i++) begin
        if (busy || sw_gnd) idle_ok = 0;
        @(negedge clk);
      end
      chk(idle_ok, "R3 idle without pulse", busy, 0);
    end

    // sweep: R1 R2 R6 R7 R8
    for (int md = 0; md < 4; md++)
      for (int ci = 0; ci < 4; ci++)
        for (int m = 0; m < 4; m++)
          for (int c = 0; c < 4; c++) begin
            logic [3:0] cpv;
            int exp;
            cpv = (ci == 0) ? 4'h0 : (ci == 1) ? 4'h1 : (ci == 2) ? 4'h5 : 4'hF;
            clkdiv_mode = 2'(md); cp_user = cpv; mod_m = 12'(m); clk_div = 12'(c);
            exp = (md == 1 && cpv == 0) ? m * c : 0;
            pulse();
            count_open(n);
            chk(n == exp, "R1/R2/R6/R8 window length", n, exp);
            chk(cp_eff == cpv && !sw_gnd && !busy, "R7 passthrough after", cp_eff, cpv);
          end

    // R6 large window
    clkdiv_mode = 2'b01; cp_user = 0; mod_m = 12'd37; clk_div = 12'd23;
    pulse(); count_open(n);
    chk(n == 37 * 23, "R6 long window", n, 851);

    // R9 qualifying restart
    mod_m = 3; clk_div = 3;
    pulse(); count_open_limited(4, n);
    vas_done = 1'b1;
    @(negedge clk);
    vas_done = 1'b0;
    count_open(n2);
    chk(n + 1 + n2 == 14, "R9 restart", n + 1 + n2, 14);

    // R9 non-qualifying pulse ignored
    pulse(); count_open_limited(4, n);
    clkdiv_mode = 2'b10;
    vas_done = 1'b1;
    @(negedge clk);
    vas_done = 1'b0; clkdiv_mode = 2'b01;
    count_open(n2);
    chk(n + 1 + n2 == 9, "R9 unqualified ignored (mode)", n + 1 + n2, 9);

    pulse(); count_open_limited(2, n);
    cp_user = 4'h3; vas_done = 1'b1;
    @(negedge clk);
    vas_done = 1'b0;
    count_open(n2);
    chk(n + 1 + n2 == 9, "R9 unqualified ignored (cp)", n + 1 + n2, 9);
    chk(cp_eff == 4'h3, "R7 passthrough nonzero", cp_eff, 3);
    cp_user = 0;

    // R12 M/CDIV changes mid-window
    mod_m = 2; clk_div = 4;
    pulse(); count_open_limited(2, n);
    mod_m = 7; clk_div = 9;
    count_open(n2);
    chk(n + n2 == 8, "R12 latched product", n + n2, 8);

    // R11 reset mid-window
    mod_m = 5; clk_div = 5; cp_user = 0;
    pulse(); count_open_limited(3, n);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !sw_gnd && cp_eff == cp_user, "R11 reset closes window", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R11 stays idle after reset", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic count_open_limited(input int lim, output int n);
    n = 0;
    while (busy && n < lim) begin
      if (cp_eff != 4'hF || !sw_gnd) chk(0, "R4/R5 during window", {cp_eff, sw_gnd}, 31);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule